// File: doc/BRIEF.md
# Synchronous Serial Port with Block Transfer

This block moves data over a three-wire synchronous serial link: a clock, a data-out line and a data-in line. Each transfer shifts a programmed number of bits, from 1 up to 256, in single-bit steps. The bits are exchanged a byte at a time through a byte buffer interface. Before each byte the port takes a transmit byte from the buffer side with a valid/ready handshake. It hands the received byte back on a second valid/ready pair after the eighth bit, or after the last bit of a partial final byte. The bit order within a byte is selectable.

As clock master, the port makes the serial clock from a programmable divider, so each clock phase lasts `cfg_baud + 1` cycles of the block clock. As clock slave, it follows the edges on `sck_i`; these are assumed to be synchronous to `clk` already. Output data changes on falling serial-clock edges and input data is sampled on rising edges. Between bytes the clock is held high while the next byte is fetched and the previous one drained. That pause is at least `STRETCH` extra cycles long.

A transfer can be suspended, but it stops only at a byte boundary. It continues after a resume. In slave mode, clock edges that arrive within `HOLDOFF` cycles of the first byte load are ignored. When the last bit is shifted, the port raises `done`, idles the clock high and ignores further clock edges until the next start.

Top module: `ssp_block`

## Requirements
- R1: Bit k of a byte (k = 0 first) goes out as tx byte bit k when `cfg_msb_first` = 0, or bit 7-k when it is 1. Received bit k is stored at the same position. In a partial final byte of n bits, only the first n positions of that order are used and the other positions of the received byte read 0.
- R2: In master mode, every low phase of `sck_o` lasts exactly `cfg_baud`+1 clock cycles. Every high phase inside a byte lasts exactly the same. `sck_o` is 1 whenever the port is not busy.
- R3: `sdo` changes only on a falling serial-clock edge. `sdi` is sampled on the rising edge.
- R4: One transfer produces exactly `cfg_count` clock pulses. A count of 0 means 256.
- R5: Each byte starts only after a transmit byte has been taken (`tx_valid` and `tx_ready` both high) and the previous received byte has been drained. `rx_valid` and `rx_data` hold steady until `rx_ready` is high.
- R6: In master mode, the high phase between two bytes lasts at least `cfg_baud` + `STRETCH` + 2 cycles.
- R7: A `suspend` pulse during a transfer stops the clock, held high, at the next byte boundary. The transfer continues after a `resume` pulse, with no bits lost.
- R8: After the final bit, `done` = 1 and `busy` = 0. Later clock edges change neither `sdo` nor `rx_valid` until the next `start`, and `start` clears `done`.
- R9: In slave mode, clock edges in the first `HOLDOFF` cycles after the first byte is loaded neither shift data nor change `sdo`.
- R10: After reset, `sck_o` = 1, `sdo` = 1, `busy` = 0, `done` = 0, `rx_valid` = 0 and `tx_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | 1: port drives the serial clock; 0: follows `sck_i` |
| cfg_msb_first | input | 1 | 1: bit 7 first; 0: bit 0 first |
| cfg_baud | input | BAUD_W | Clock phase length minus one, in block clocks |
| cfg_count | input | COUNT_W | Bits per transfer; 0 means 2**COUNT_W |
| start | input | 1 | Pulse: begin a transfer (ignored while busy) |
| suspend | input | 1 | Pulse: pause at the next byte boundary |
| resume | input | 1 | Pulse: continue a paused transfer |
| tx_data | input | 8 | Next transmit byte |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Port is ready to take a transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` holds an undrained byte |
| rx_ready | input | 1 | Buffer side accepts `rx_data` |
| sck_i | input | 1 | Serial clock in (slave mode) |
| sck_o | output | 1 | Serial clock out (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |

## Verification
Master-mode transfers are swept over both bit orders, two divider settings and every bit count from 1 to 17, plus 24 and 256. This separates off-by-one faults in the bit counter, errors in the partial-byte alignment and errors in the phase timing. The transmit and receive buffers are stalled in a changing pattern, which shows whether a byte boundary waits on both handshakes. A slave-mode transfer starts with a stray clock pulse inside the hold-off window and sends extra pulses after `done`; a stray shift there would offset every later bit. A suspended transfer must stop after exactly eight pulses and then finish with intact data.

// File: rtl/ssp_pkg.sv
// Package: shared types and helpers for the synchronous serial port.
// Assumes bytes of 8 bits; bit lanes are 3-bit indices.
package ssp_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_GAP,
        ST_RUN,
        ST_PAUSE
    } ssp_state_e;

    // Byte position used for serial bit k under the chosen order.
    function automatic logic [2:0] bit_lane(input logic msb_first, input logic [2:0] k);
        return msb_first ? (3'd7 - k) : k;
    endfunction

endpackage

// File: rtl/ssp_baud.sv
// Phase divider: while run is high, pulses expire once every div+1 cycles.
// Assumes div is held stable during a transfer; the count restarts whenever run drops.
module ssp_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             expire
);

    logic [DIV_W-1:0] cnt_q;

    assign expire = run && (cnt_q == div);

    // Count cycles within one serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ssp_sck.sv
// Serial clock unit: makes the master clock level and turns either the master
// phase expiry or edges on the slave clock input into fall/rise events.
// Assumes sck_i is already synchronous to clk.
module ssp_sck (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic run,
    input  logic expire,
    input  logic sck_i,
    output logic sck_o,
    output logic fall_ev,
    output logic rise_ev
);

    logic sck_q;
    logic sin_q;

    assign sck_o = sck_q;

    // Master clock level: idles high, toggles on each phase expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck_q <= 1'b1;
        end else if (master && expire) begin
            sck_q <= ~sck_q;
        end
    end

    // Previous slave clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_q <= 1'b1;
        end else begin
            sin_q <= sck_i;
        end
    end

    // Edge events from whichever clock source is selected.
    always_comb begin
        if (master) begin
            fall_ev = run && expire && sck_q;
            rise_ev = run && expire && !sck_q;
        end else begin
            fall_ev = run && sin_q && !sck_i;
            rise_ev = run && !sin_q && sck_i;
        end
    end

endmodule

// File: rtl/ssp_ctrl.sv
// Transfer sequencer: loads bytes, inserts the inter-byte gap (or the slave
// hold-off before the first byte), counts bits, handles suspend/resume at byte
// boundaries and raises done. Assumes cfg inputs are stable while busy.
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int COUNT_W = 8,
    parameter int STRETCH = 2,
    parameter int HOLDOFF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master,
    input  logic [COUNT_W-1:0] count,
    input  logic               start,
    input  logic               suspend,
    input  logic               resume,
    input  logic               tx_valid,
    input  logic               rx_pending,
    input  logic               fall_ev,
    input  logic               rise_ev,
    output logic               run,
    output logic               tx_ready,
    output logic               tx_take,
    output logic               shift_out,
    output logic               shift_in,
    output logic               byte_end,
    output logic [2:0]         bit_k,
    output logic               busy,
    output logic               paused,
    output logic               done
);

    localparam int REM_W   = COUNT_W + 1;
    localparam int GAP_MAX = (STRETCH > HOLDOFF) ? STRETCH : HOLDOFF;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    ssp_state_e       state_q;
    logic [REM_W-1:0] remain_q;
    logic [2:0]       bit_k_q;
    logic             low_q;
    logic [GAP_W-1:0] gap_q;
    logic             first_q;
    logic             pend_q;
    logic             done_q;
    logic [REM_W-1:0] load_count;
    logic [GAP_W-1:0] gap_last;

    assign load_count = (count == '0) ? (REM_W'(1) << COUNT_W) : REM_W'(count);
    assign gap_last   = (first_q && !master) ? GAP_W'(HOLDOFF - 1) : GAP_W'(STRETCH - 1);

    assign run       = (state_q == ST_RUN);
    assign tx_ready  = (state_q == ST_LOAD) && !rx_pending;
    assign tx_take   = tx_ready && tx_valid;
    assign shift_out = run && fall_ev;
    assign shift_in  = run && rise_ev && low_q;
    assign byte_end  = shift_in && ((remain_q == REM_W'(1)) || (bit_k_q == 3'd7));
    assign bit_k     = bit_k_q;
    assign busy      = (state_q != ST_IDLE);
    assign paused    = (state_q == ST_PAUSE);
    assign done      = done_q;

    // Sequencer state, bit counters and suspend request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            bit_k_q  <= '0;
            low_q    <= 1'b0;
            gap_q    <= '0;
            first_q  <= 1'b0;
            pend_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (suspend && busy) begin
                pend_q <= 1'b1;
            end
            if (resume) begin
                pend_q <= 1'b0;
            end
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_LOAD;
                        remain_q <= load_count;
                        bit_k_q  <= '0;
                        low_q    <= 1'b0;
                        first_q  <= 1'b1;
                        pend_q   <= 1'b0;
                        done_q   <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (tx_take) begin
                        state_q <= ST_GAP;
                        gap_q   <= '0;
                    end
                end
                ST_GAP: begin
                    if (gap_q == gap_last) begin
                        state_q <= ST_RUN;
                        first_q <= 1'b0;
                        low_q   <= 1'b0;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (fall_ev) begin
                        low_q <= 1'b1;
                    end
                    if (shift_in) begin
                        low_q    <= 1'b0;
                        remain_q <= remain_q - 1'b1;
                        bit_k_q  <= bit_k_q + 1'b1;
                        if (remain_q == REM_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else if (bit_k_q == 3'd7) begin
                            if (pend_q && !resume) begin
                                state_q <= ST_PAUSE;
                                pend_q  <= 1'b0;
                            end else begin
                                state_q <= ST_LOAD;
                            end
                        end
                    end
                end
                ST_PAUSE: begin
                    if (resume) begin
                        state_q <= ST_LOAD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ssp_shift.sv
// Byte datapath: holds the transmit byte, drives sdo bit by bit, assembles the
// received byte by lane and hands it out with a valid/ready pair.
// Assumes a new byte is loaded only when the receive slot is empty.
module ssp_shift
    import ssp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       msb_first,
    input  logic       tx_take,
    input  logic [7:0] tx_data,
    input  logic       shift_out,
    input  logic       shift_in,
    input  logic       byte_end,
    input  logic [2:0] bit_k,
    input  logic       sdi,
    input  logic       rx_ready,
    output logic       sdo,
    output logic [7:0] rx_data,
    output logic       rx_valid
);

    logic [7:0] tx_buf_q;
    logic [7:0] rx_acc_q;
    logic [7:0] rx_next;
    logic [2:0] lane;

    assign lane = bit_lane(msb_first, bit_k);

    // Receive byte with the current input bit placed in its lane.
    always_comb begin
        rx_next       = rx_acc_q;
        rx_next[lane] = sdi;
    end

    // Transmit byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_q <= '0;
        end else if (tx_take) begin
            tx_buf_q <= tx_data;
        end
    end

    // Receive accumulator, cleared at each byte load.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_take) begin
            rx_acc_q <= '0;
        end else if (shift_in) begin
            rx_acc_q <= rx_next;
        end
    end

    // Received byte hand-off to the buffer side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else if (byte_end) begin
            rx_data  <= rx_next;
            rx_valid <= 1'b1;
        end else if (rx_valid && rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    // Serial output, updated on falling serial clock events only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b1;
        end else if (shift_out) begin
            sdo <= tx_buf_q[lane];
        end
    end

endmodule

// File: rtl/ssp_block.sv
// Top level of the synchronous serial port with block transfer.
// Ties the phase divider, clock unit, sequencer and byte datapath together.
// Assumes configuration inputs do not change while busy is high.
module ssp_block #(
    parameter int BAUD_W  = 8,
    parameter int COUNT_W = 8,
    parameter int STRETCH = 2,
    parameter int HOLDOFF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master,
    input  logic               cfg_msb_first,
    input  logic [BAUD_W-1:0]  cfg_baud,
    input  logic [COUNT_W-1:0] cfg_count,
    input  logic               start,
    input  logic               suspend,
    input  logic               resume,
    input  logic [7:0]         tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    input  logic               rx_ready,
    input  logic               sck_i,
    output logic               sck_o,
    output logic               sck_oe,
    output logic               sdo,
    input  logic               sdi,
    output logic               busy,
    output logic               done
);

    logic       run;
    logic       expire;
    logic       fall_ev;
    logic       rise_ev;
    logic       tx_take;
    logic       shift_out;
    logic       shift_in;
    logic       byte_end;
    logic [2:0] bit_k;
    logic       paused;

    assign sck_oe = cfg_master;

    ssp_baud #(.DIV_W(BAUD_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div    (cfg_baud),
        .expire (expire)
    );

    ssp_sck u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .master  (cfg_master),
        .run     (run),
        .expire  (expire),
        .sck_i   (sck_i),
        .sck_o   (sck_o),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    ssp_ctrl #(
        .COUNT_W (COUNT_W),
        .STRETCH (STRETCH),
        .HOLDOFF (HOLDOFF)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .master     (cfg_master),
        .count      (cfg_count),
        .start      (start),
        .suspend    (suspend),
        .resume     (resume),
        .tx_valid   (tx_valid),
        .rx_pending (rx_valid),
        .fall_ev    (fall_ev),
        .rise_ev    (rise_ev),
        .run        (run),
        .tx_ready   (tx_ready),
        .tx_take    (tx_take),
        .shift_out  (shift_out),
        .shift_in   (shift_in),
        .byte_end   (byte_end),
        .bit_k      (bit_k),
        .busy       (busy),
        .paused     (paused),
        .done       (done)
    );

    ssp_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .msb_first (cfg_msb_first),
        .tx_take   (tx_take),
        .tx_data   (tx_data),
        .shift_out (shift_out),
        .shift_in  (shift_in),
        .byte_end  (byte_end),
        .bit_k     (bit_k),
        .sdi       (sdi),
        .rx_ready  (rx_ready),
        .sdo       (sdo),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

endmodule

// File: rtl/ssp_block_chk.sv
// Checker for ssp_block: protocol and timing properties, bound to the top.
module ssp_block_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_master,
    input logic       sck_o,
    input logic       sdo,
    input logic       busy,
    input logic       done,
    input logic       tx_ready,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       paused,
    input logic [2:0] bit_k
);

    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o); // R2

    AST_SDO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $past(sck_o) && sck_o) |-> $stable(sdo)); // R3

    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R5

    AST_TX_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> ((bit_k == 3'd0) && sck_o)); // R5

    AST_PAUSE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> ((bit_k == 3'd0) && sck_o && busy)); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

endmodule

bind ssp_block ssp_block_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .sck_o      (sck_o),
    .sdo        (sdo),
    .busy       (busy),
    .done       (done),
    .tx_ready   (tx_ready),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .paused     (paused),
    .bit_k      (bit_k)
);

// File: tb/test_ssp_block.sv
// Bench for ssp_block: sweeps bit counts, orders and divider settings,
// with expected data computed from bit index arithmetic.
module test_ssp_block;

    localparam int STRETCH = 2;
    localparam int HOLDOFF = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1;
    logic       cfg_msb_first = 1'b0;
    logic [7:0] cfg_baud = '0;
    logic [7:0] cfg_count = '0;
    logic       start = 1'b0;
    logic       suspend = 1'b0;
    logic       resume = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       sck_i = 1'b1;
    logic       sck_o;
    logic       sck_oe;
    logic       sdo;
    logic       sdi = 1'b0;
    logic       busy;
    logic       done;

    always #2 clk = ~clk;

    ssp_block #(
        .BAUD_W  (8),
        .COUNT_W (8),
        .STRETCH (STRETCH),
        .HOLDOFF (HOLDOFF)
    ) i_ssp_block (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_master    (cfg_master),
        .cfg_msb_first (cfg_msb_first),
        .cfg_baud      (cfg_baud),
        .cfg_count     (cfg_count),
        .start         (start),
        .suspend       (suspend),
        .resume        (resume),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_ready      (rx_ready),
        .sck_i         (sck_i),
        .sck_o         (sck_o),
        .sck_oe        (sck_oe),
        .sdo           (sdo),
        .sdi           (sdi),
        .busy          (busy),
        .done          (done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int seed = 0;
    int n_bits = 0;
    int baud_v = 0;
    bit msb_v = 1'b0;
    bit master_v = 1'b1;
    bit mon_en = 1'b0;
    bit easy = 1'b1;
    int falls, rises, hi_len, lo_len, tx_idx, rx_idx;
    bit took = 1'b0;
    bit prev_obs = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] f_tx(input int j);
        return 8'((j * 37 + seed * 11 + 90) % 256);
    endfunction

    function automatic logic f_sdi(input int i);
        return 1'(((i * 13 + seed * 3) >> 2) ^ (i & 1));
    endfunction

    function automatic int f_lane(input bit msb, input int k);
        return msb ? (7 - k) : k;
    endfunction

    function automatic logic [7:0] exp_rx(input int j);
        logic [7:0] v = '0;
        for (int k = 0; k < 8; k++) begin
            if (8 * j + k < n_bits) v[f_lane(msb_v, k)] = f_sdi(8 * j + k);
        end
        return v;
    endfunction

    // Buffer-side models and serial line monitor, all on the falling clock edge.
    always @(negedge clk) begin
        logic obs;
        logic [7:0] tb;
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (took) tx_idx++;
        tx_valid = easy ? 1'b1 : ((cyc + seed) % 5 != 0);
        tx_data  = f_tx(tx_idx);
        took     = tx_valid && tx_ready;
        rx_ready = easy ? 1'b1 : ((cyc * 3 + seed) % 7 != 0);
        if (rx_valid && rx_ready) begin
            chk(rx_data == exp_rx(rx_idx), "R1 received byte", int'(rx_data), int'(exp_rx(rx_idx)));
            rx_idx++;
        end
        obs = master_v ? sck_o : sck_i;
        if (mon_en) begin
            if (prev_obs && !obs) begin
                if (master_v && falls > 0) begin
                    if (falls % 8 == 0)
                        chk(hi_len >= STRETCH + baud_v + 2, "R6 inter-byte high", hi_len, STRETCH + baud_v + 2);
                    else
                        chk(hi_len == baud_v + 1, "R2 high phase", hi_len, baud_v + 1);
                end
                if (master_v) sdi = f_sdi(falls);
                falls++;
                hi_len = 0;
                lo_len = 0;
            end else if (!prev_obs && obs) begin
                if (master_v) chk(lo_len == baud_v + 1, "R2 low phase", lo_len, baud_v + 1);
                tb = f_tx(rises / 8);
                chk(sdo == tb[f_lane(msb_v, rises % 8)], "R1 R3 sdo bit", int'(sdo), int'(tb[f_lane(msb_v, rises % 8)]));
                rises++;
                hi_len = 0;
                lo_len = 0;
            end
            if (obs) hi_len++;
            else lo_len++;
        end
        prev_obs = obs;
    end

    task automatic clear_counts();
        falls = 0; rises = 0; hi_len = 0; lo_len = 0;
        tx_idx = 0; rx_idx = 0; took = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R8 done raised", int'(done), 1);
    endtask

    task automatic final_checks();
        repeat (30) @(negedge clk);
        chk(falls == n_bits, "R4 clock pulses", falls, n_bits);
        chk(rx_idx == (n_bits + 7) / 8, "R5 bytes received", rx_idx, (n_bits + 7) / 8);
        chk(tx_idx == (n_bits + 7) / 8, "R5 bytes taken", tx_idx, (n_bits + 7) / 8);
        chk(!busy && sck_o && done, "R8 idle after done", int'({busy, sck_o, done}), 3);
    endtask

    task automatic run_master(input bit msb, input int n, input int baud, input bit do_pause);
        @(negedge clk);
        master_v = 1'b1; msb_v = msb; n_bits = n; baud_v = baud; easy = 1'b0;
        seed = n * 3 + baud + (msb ? 7 : 0);
        cfg_master = 1'b1; cfg_msb_first = msb; cfg_baud = 8'(baud); cfg_count = 8'(n);
        clear_counts();
        mon_en = 1'b1;
        pulse_start();
        if (do_pause) begin
            repeat (5) @(negedge clk);
            suspend = 1'b1; @(negedge clk); suspend = 1'b0;
            repeat (300) @(negedge clk);
            chk(falls == 8, "R7 stopped at byte boundary", falls, 8);
            repeat (50) @(negedge clk);
            chk(falls == 8, "R7 no pulses while paused", falls, 8);
            chk(busy && sck_o, "R7 paused busy, clock high", int'({busy, sck_o}), 3);
            resume = 1'b1; @(negedge clk); resume = 1'b0;
        end
        wait_done();
        final_checks();
        mon_en = 1'b0;
    endtask

    task automatic slave_edge(input logic lvl);
        @(negedge clk); #1 sck_i = lvl;
    endtask

    initial begin
        logic sdo_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(sck_o == 1'b1, "R10 sck_o", int'(sck_o), 1);
        chk(sdo == 1'b1, "R10 sdo", int'(sdo), 1);
        chk(!busy && !done, "R10 busy/done", int'({busy, done}), 0);
        chk(!rx_valid && !tx_ready, "R10 handshake", int'({rx_valid, tx_ready}), 0);

        // Slave transfer with a stray pulse in the hold-off window (R9, R8)
        master_v = 1'b0; msb_v = 1'b1; n_bits = 12; seed = 3; easy = 1'b1;
        cfg_master = 1'b0; cfg_msb_first = 1'b1; cfg_count = 8'd12;
        clear_counts();
        mon_en = 1'b0;
        pulse_start();
        slave_edge(1'b0);
        repeat (2) @(negedge clk);
        slave_edge(1'b1);
        @(negedge clk);
        chk(sdo == 1'b1, "R9 sdo unchanged in hold-off", int'(sdo), 1);
        chk(busy == 1'b1, "R9 still busy", int'(busy), 1);
        repeat (20) @(negedge clk);
        mon_en = 1'b1;
        for (int i = 0; i < n_bits; i++) begin
            if (i > 0 && i % 8 == 0) repeat (8) @(negedge clk);
            @(negedge clk); #1 sck_i = 1'b0; sdi = f_sdi(i);
            repeat (3) @(negedge clk);
            #1 sck_i = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R8 slave done", int'(done), 1);
        mon_en = 1'b0;
        repeat (5) @(negedge clk);
        sdo_before = sdo;
        slave_edge(1'b0); repeat (3) @(negedge clk);
        slave_edge(1'b1); repeat (3) @(negedge clk);
        chk(sdo == sdo_before, "R8 sdo ignores late clocks", int'(sdo), int'(sdo_before));
        chk(!rx_valid && done, "R8 no new byte after done", int'({rx_valid, done}), 1);
        chk(falls == 12, "R4 slave pulses", falls, 12);
        chk(rx_idx == 2, "R5 slave bytes", rx_idx, 2);

        // Master sweep over order, divider and bit count (R1 R2 R3 R4 R5 R6)
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 2; b++) begin
                for (int n = 1; n <= 18; n++) begin
                    run_master(m[0], (n == 18) ? 24 : n, b * 2, 1'b0);
                end
            end
        end
        // R4: count 0 means 256 bits
        run_master(1'b0, 256, 0, 1'b0);
        run_master(1'b1, 256, 0, 1'b0);
        // R7: suspend and resume
        run_master(1'b0, 24, 3, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule